// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

The block times the interval between successive rising edges of a fan's tachometer pin and counts it in system clock cycles. The pin is asynchronous, so it first passes through a synchroniser. Each completed interval is loaded into a measurement output and marked by a one-cycle new-measurement pulse. A fan may give one, two or four pulses per revolution. The block always measures a single pulse-to-pulse interval and leaves conversion to speed to software.

When checking is enabled, each new measurement is compared against a reference period widened by a tolerance on both sides. A result outside that window raises a one-cycle tach-error pulse together with the new-measurement pulse. Software normally programs the reference with a recent measurement and the tolerance with about a quarter of it.

A fan that stops gives no more edges. When the running count reaches a timeout limit, the block reports a tach error, clears the measurement to zero and waits for a fresh edge before timing again. A zero measurement therefore means "no valid reading", and zero is also the value out of reset.

Top module: `fan_tach_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `meas_o` is 0 and `new_meas_o` and `tach_err_o` are low.
- R2: A measurement equals the number of clock cycles between two consecutive rising edges of `tach_i`. The first rising edge after reset or after a stall only starts timing and produces no event. A reported measurement is never 0.
- R3: Each completed measurement loads `meas_o` and raises `new_meas_o` for exactly one cycle, in the same cycle. Every measurement is reported once, in order.
- R4: `meas_o` keeps its value in every cycle in which neither `new_meas_o` nor `tach_err_o` is high.
- R5: With `chk_en_i` = 1, `tach_err_o` rises together with `new_meas_o` when the measurement is below reference minus tolerance or above reference plus tolerance. Both bounds are inclusive (inside the window, no error).
- R6: When the tolerance exceeds the reference, the lower bound is 0. The upper bound is formed one bit wider than the count, so it never wraps to a small value.
- R7: With `chk_en_i` = 0, a measurement never raises `tach_err_o`, even when it lies outside the window.
- R8: If `TIMEOUT_CYC` cycles pass after a rising edge with no further rising edge, `tach_err_o` pulses for one cycle without `new_meas_o`, and `meas_o` becomes 0. Timing restarts only at the next rising edge, which then behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tach_i | input | 1 | Asynchronous tachometer pin |
| chk_en_i | input | 1 | Enables the window check |
| ref_period_i | input | CNT_W | Reference period in clock cycles |
| tolerance_i | input | CNT_W | Allowed deviation either side of the reference |
| meas_o | output | CNT_W | Last measured period, 0 when invalid |
| new_meas_o | output | 1 | One-cycle pulse when a measurement completes |
| tach_err_o | output | 1 | One-cycle pulse on an out-of-window measurement or a stall |

## Verification
The bound checker checks several properties on every cycle:
- the new-measurement pulse lasts a single cycle;
- a reported period is never zero;
- the measurement holds between events;
- an error raised without a measurement leaves zero behind;
- a disabled check never flags a measurement.

The actual period values, the inclusive window bounds, the saturating lower bound and the non-wrapping upper bound can only be shown by the bench. So can the arming rule after reset and after a stall. The bench drives edge trains with chosen spacings and compares each reported result against a queue of periods and verdicts it computed itself.

// File: rtl/fan_tach_pkg.sv
// Package: shared types for the fan tachometer period monitor.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package fan_tach_pkg;

    // Default count width: at 100 MHz about 10 ms of range.
    localparam int DEFAULT_CNT_W = 20;

    // Timing state of the period counter.
    typedef enum logic {
        TMR_IDLE = 1'b0,   // waiting for an edge to start timing
        TMR_RUN  = 1'b1    // counting cycles since the last edge
    } tmr_state_e;

endpackage

// File: rtl/tach_edge_sync.sv
// Module: tach_edge_sync
// Brings the asynchronous tach pin into the clock domain through a
// chain of STAGES flops, then flags each rising edge for one cycle.
// Assumes the pin stays at each level for at least two clock cycles.
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain, one generated flop per stage.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // Later stages follow the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // A rising edge is a high synchronised level after a low one.
    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tach_period_counter.sv
// Module: tach_period_counter
// Counts cycles between edge strobes. It reports a finished interval
// through done_o/period_o, and a stall when TIMEOUT_CYC cycles pass
// without an edge. Assumes 1 < TIMEOUT_CYC < 2**CNT_W.
module tach_period_counter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W       = DEFAULT_CNT_W,
    parameter int TIMEOUT_CYC = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             done_o,
    output logic             stall_o,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] TMO_LIMIT = CNT_W'(TIMEOUT_CYC);

    tmr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc  = cnt_q + 1'b1;
    assign period_o = cnt_inc;

    // An interval completes on an edge while timing. An edge takes priority over a stall.
    assign done_o  = (state_q == TMR_RUN) && rise_i;
    assign stall_o = (state_q == TMR_RUN) && !rise_i && (cnt_inc == TMO_LIMIT);

    // Advance the count, restart it on an edge, and drop to idle on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                TMR_IDLE: begin
                    cnt_q <= '0;
                    if (rise_i) state_q <= TMR_RUN;
                end
                default: begin
                    if (rise_i) begin
                        cnt_q <= '0;
                    end else if (stall_o) begin
                        cnt_q   <= '0;
                        state_q <= TMR_IDLE;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tach_window_check.sv
// Module: tach_window_check
// Combinational test of a period against reference +/- tolerance.
// The lower bound saturates at zero. The upper bound is one bit wider so
// that it cannot wrap. Both bounds count as inside the window.
module tach_window_check #(
    parameter int CNT_W = 20
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] ref_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             outside_o
);
    logic [CNT_W:0]   hi_bound;
    logic [CNT_W-1:0] lo_bound;

    // Derive both bounds and compare the period with them.
    always_comb begin
        hi_bound  = {1'b0, ref_i} + {1'b0, tol_i};
        lo_bound  = (tol_i > ref_i) ? '0 : (ref_i - tol_i);
        outside_o = (period_i < lo_bound) || ({1'b0, period_i} > hi_bound);
    end
endmodule

// File: rtl/fan_tach_monitor.sv
// Module: fan_tach_monitor (top)
// Tach period monitor: synchroniser, period counter and window check,
// with registered measurement and event outputs.
// Assumes ref/tolerance/check-enable are quasi-static; the values present
// in the cycle an interval completes are the ones used.
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int CNT_W       = DEFAULT_CNT_W,
    parameter int TIMEOUT_CYC = 1_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_i,
    input  logic             chk_en_i,
    input  logic [CNT_W-1:0] ref_period_i,
    input  logic [CNT_W-1:0] tolerance_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             new_meas_o,
    output logic             tach_err_o
);
    logic             rise;
    logic             done;
    logic             stall;
    logic             outside;
    logic [CNT_W-1:0] period;

    tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (tach_i),
        .rise_o (rise)
    );

    tach_period_counter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .done_o   (done),
        .stall_o  (stall),
        .period_o (period)
    );

    tach_window_check #(.CNT_W(CNT_W)) u_win (
        .period_i  (period),
        .ref_i     (ref_period_i),
        .tol_i     (tolerance_i),
        .outside_o (outside)
    );

    // Register the measurement and the events; a stall clears the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_o     <= '0;
            new_meas_o <= 1'b0;
            tach_err_o <= 1'b0;
        end else begin
            new_meas_o <= done;
            tach_err_o <= (done && chk_en_i && outside) || stall;
            if (done)       meas_o <= period;
            else if (stall) meas_o <= '0;
        end
    end
endmodule

// File: rtl/fan_tach_monitor_chk.sv
// Module: fan_tach_monitor_chk
// Cycle-by-cycle properties of the monitor's outputs, bound to the top.
module fan_tach_monitor_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en_i,
    input logic [CNT_W-1:0] meas_o,
    input logic             new_meas_o,
    input logic             tach_err_o
);
    // R3: the measurement event lasts one cycle.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_meas_o |=> !new_meas_o);

    // R2: a reported period is never zero.
    assert_nonzero_meas_R2: assert property (@(posedge clk) disable iff (!rst_n)
        new_meas_o |-> (meas_o != '0));

    // R4: the measurement holds while no event is raised.
    assert_meas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_meas_o && !tach_err_o) |-> $stable(meas_o));

    // R8: an error without a measurement is a stall and leaves zero.
    assert_stall_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tach_err_o && !new_meas_o) |-> (meas_o == '0));

    // R7: with checking off in the deciding cycle, no measurement error.
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (new_meas_o && !$past(chk_en_i)) |-> !tach_err_o);
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en_i   (chk_en_i),
    .meas_o     (meas_o),
    .new_meas_o (new_meas_o),
    .tach_err_o (tach_err_o)
);

// File: tb/fan_tach_monitor_tb.sv
// Scoreboard bench. The driver pushes the expected period/verdict for each
// edge it produces, and the monitor pops one entry per output event.
module fan_tach_monitor_tb;
    localparam int CNT_W = 12;
    localparam int TMO   = 300;

    typedef struct {
        logic             stall;
        logic [CNT_W-1:0] meas;
        logic             err;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tach = 1'b0;
    logic             chk_en = 1'b0;
    logic [CNT_W-1:0] ref_p = '0;
    logic [CNT_W-1:0] tol = '0;
    logic [CNT_W-1:0] meas;
    logic             new_meas;
    logic             terr;

    int   checks = 0;
    int   fails = 0;
    bit   armed = 0;
    bit   mon_en = 0;
    bit   done = 0;
    logic [CNT_W-1:0] last_meas = '0;
    exp_t q[$];

    always #5 clk = ~clk;

    fan_tach_monitor #(.CNT_W(CNT_W), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .tach_i(tach), .chk_en_i(chk_en),
        .ref_period_i(ref_p), .tolerance_i(tol),
        .meas_o(meas), .new_meas_o(new_meas), .tach_err_o(terr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one rising edge, then wait so the next edge is gap cycles later.
    task automatic edge_gap(input int gap);
        exp_t e;
        int   p;
        int   lo;
        int   hi;
        @(negedge clk);
        tach = 1'b1;
        if (armed) begin
            p  = gap_prev;
            lo = (int'(tol) > int'(ref_p)) ? 0 : int'(ref_p) - int'(tol);
            hi = int'(ref_p) + int'(tol);
            e.stall = 1'b0;
            e.meas  = CNT_W'(p);
            e.err   = chk_en && (p < lo || p > hi);
            q.push_back(e);
        end
        armed = 1;
        gap_prev = gap;
        repeat (2) @(negedge clk);
        tach = 1'b0;
        repeat (gap - 3) @(negedge clk);
    endtask
    int gap_prev = 0;

    // Let the line stay low past the timeout; expect a stall.
    task automatic stall_wait();
        exp_t e;
        e.stall = 1'b1;
        e.meas  = '0;
        e.err   = 1'b1;
        q.push_back(e);
        armed = 0;
        repeat (TMO + 20) @(negedge clk);
    endtask

    // Monitor: compare each event with the queue head and check hold otherwise.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (new_meas || terr) begin
                    if (q.size() == 0) begin
                        check(0, "R3 unexpected event", int'(meas), -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        if (e.stall) begin
                            check(terr && !new_meas, "R8 stall flag", int'({terr, new_meas}), 2);
                            check(meas == '0, "R8 stall clears meas", int'(meas), 0);
                        end else begin
                            check(new_meas, "R3 new_meas pulse", int'(new_meas), 1);
                            check(meas == e.meas, "R2 period", int'(meas), int'(e.meas));
                            check(terr == e.err, "R5/R6/R7 error verdict", int'(terr), int'(e.err));
                        end
                    end
                    last_meas = meas;
                end else begin
                    check(meas == last_meas, "R4 hold", int'(meas), int'(last_meas));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(meas == '0 && !new_meas && !terr, "R1 reset", int'(meas), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(meas == '0 && !new_meas && !terr, "R1 after release", int'(meas), 0);
        mon_en = 1;

        // R2/R3/R7: check off, window (0,0) would reject all
        chk_en = 0; ref_p = '0; tol = '0;
        edge_gap(50); edge_gap(37); edge_gap(120); edge_gap(60);

        // R5: window 100 +/- 25, inclusive bounds and one beyond
        chk_en = 1; ref_p = 12'd100; tol = 12'd25;
        edge_gap(100); edge_gap(75); edge_gap(125); edge_gap(74);
        edge_gap(126); edge_gap(90); edge_gap(40);

        // R6: tolerance above reference -> lower bound 0
        ref_p = 12'd10; tol = 12'd20;
        edge_gap(5); edge_gap(30); edge_gap(31); edge_gap(20);

        // R6: upper bound must not wrap (250 + 4000 > 4095)
        ref_p = 12'd250; tol = 12'd4000;
        edge_gap(200); edge_gap(9); edge_gap(80);

        // R8: stall, then re-arm; the first edge afterwards makes no event
        stall_wait();
        ref_p = 12'd60; tol = 12'd6;
        edge_gap(60); edge_gap(66); edge_gap(53); edge_gap(30);
        stall_wait();

        // R2: an arming edge alone followed by a stall
        edge_gap(40);
        stall_wait();
        repeat (10) @(negedge clk);

        check(q.size() == 0, "R3 all expected events seen", q.size(), 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule